// File: doc/BRIEF.md
# Shared-Temp Wide Register Bridge

The bridge lets a CPU with an 8-bit data bus read and write a bank of 16-bit peripheral registers so that both bytes move in one step. All of the 16-bit registers share one 8-bit holding byte. The two byte accesses go through this holding byte. The access to the low byte is the event that moves the whole word.

To write a register, software first writes the high-byte address. This loads only the holding byte. Software then writes the low-byte address, which commits the holding byte and the new low byte into the register on the same clock edge. To read a register, software first reads the low-byte address. That access returns the low byte and, on the same edge, copies the register's high byte into the holding byte. A later read of the high-byte address returns the holding byte.

The peripheral logic sees every register value in parallel. It sees a one-cycle commit pulse for each register. It can load a register itself through its own write enable.

Top module: `wrb_bridge`

## Requirements
- R1: After the active-low asynchronous reset, every register and the holding byte are zero, no commit pulse is high, and the read data is zero.
- R2: A write to the high-byte address of register k (byte address 2k+1) loads only the holding byte. No register changes and no commit pulse fires.
- R3: A write to the low-byte address of register k (byte address 2k) stores {holding byte, write data} into register k at that clock edge. commit_o bit k is high during the strobe cycle, and at most one commit bit is ever high.
- R4: A read of the low-byte address of register k returns bits 7:0 of register k in the same cycle as the strobe. At that clock edge the holding byte takes bits 15:8 of register k.
- R5: A read of a high-byte address returns the holding byte. It does not return the live high byte, even if the peripheral has changed the register since the low-byte read.
- R6: The holding byte is shared. A high-byte write to register A followed by a low-byte write to register B commits the held byte into B and leaves A unchanged.
- R7: A low-byte write with no high-byte write before it commits whatever the holding byte holds. This is zero after reset, or the byte from the last high-byte write or low-byte read.
- R8: hw_we_i bit k loads register k from its slice of hw_data_i at the clock edge. If a CPU commit hits the same register in the same cycle, the CPU value is stored.
- R9: A byte address at or above 2*NUM_REGS reads as zero. A write to such an address changes neither a register nor the holding byte.
- R10: rdata_o is zero in any cycle without a read strobe. A cycle with both strobes high performs only the write: the read data is zero and no snapshot is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address; bit 0 selects the high byte |
| wdata_i | input | 8 | CPU write data |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| rdata_o | output | 8 | Read data, valid in the strobe cycle |
| hw_we_i | input | NUM_REGS | Peripheral load enable per register |
| hw_data_i | input | NUM_REGS*16 | Peripheral load values, register k at bits 16k+15:16k |
| reg_q_o | output | NUM_REGS*16 | Current register values, same packing |
| commit_o | output | NUM_REGS | One-cycle pulse per register on a CPU word commit |

## Verification
On every cycle the assertions check four things. Commit pulses are one-hot. A committed word appears in the register on the next cycle, even when the peripheral writes at the same time. The holding byte stays still unless a high-byte write or a low-byte read occurs, and a low-byte read leaves the register's high byte in it. Unmapped addresses read as zero and commit nothing.

Some behaviour depends on sequences of accesses, and only the bench scenarios can show it. These are the cross-register use of the shared byte, the stale high byte returned after a peripheral update, and commits that reuse an old holding value. The bench sweeps every ordered pair of registers for these cases.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } bus_op_e;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/wrb_addr_dec.sv
module wrb_addr_dec
  import wrb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output bus_op_e             op_o,
  output half_e               half_o,
  output logic                hit_o,
  output logic [NUM_REGS-1:0] sel_o
);
  localparam int unsigned SLOT_W = ADDR_W - 1;

  logic [SLOT_W-1:0] slot;

  assign slot   = addr_i[ADDR_W-1:1];
  assign half_o = half_e'(addr_i[0]);
  assign hit_o  = ({{(32-SLOT_W){1'b0}}, slot} < 32'(NUM_REGS));

  // write has priority when both strobes are high
  always_comb begin
    if (wr_i)      op_o = OP_WRITE;
    else if (rd_i) op_o = OP_READ;
    else           op_o = OP_IDLE;
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
    assign sel_o[k] = hit_o && (slot == SLOT_W'(k));
  end
endmodule

// File: rtl/wrb_temp_byte.sv
module wrb_temp_byte
  import wrb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              load_rd_i,
  input  logic [BYTE_W-1:0] snap_i,
  output logic [BYTE_W-1:0] temp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        temp_o <= '0;
    else if (load_wr_i) temp_o <= wdata_i;
    else if (load_rd_i) temp_o <= snap_i;
  end

  // R2
  temp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_wr_i && !load_rd_i) |=> $stable(temp_o));
endmodule

// File: rtl/wrb_reg_slot.sv
module wrb_reg_slot
  import wrb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_commit_i,
  input  logic [WORD_W-1:0] cpu_word_i,
  input  logic              hw_we_i,
  input  logic [WORD_W-1:0] hw_word_i,
  output logic [WORD_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           q_o <= '0;
    else if (cpu_commit_i) q_o <= cpu_word_i;
    else if (hw_we_i)      q_o <= hw_word_i;
  end

  // R8
  cpu_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_commit_i |=> (q_o == $past(cpu_word_i)));

  // R2
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_commit_i && !hw_we_i) |=> $stable(q_o));
endmodule

// File: rtl/wrb_rd_mux.sv
module wrb_rd_mux
  import wrb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4
) (
  input  logic                       rd_en_i,
  input  half_e                      half_i,
  input  logic [NUM_REGS-1:0]        sel_i,
  input  logic [NUM_REGS*WORD_W-1:0] words_i,
  input  logic [BYTE_W-1:0]          temp_i,
  output logic [BYTE_W-1:0]          rdata_o,
  output logic [BYTE_W-1:0]          snap_o
);
  logic [NUM_REGS-1:0][BYTE_W-1:0] lo_b, hi_b;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_split
    assign lo_b[k] = words_i[k*WORD_W +: BYTE_W];
    assign hi_b[k] = words_i[k*WORD_W+BYTE_W +: BYTE_W];
  end

  logic [BYTE_W-1:0] lo_sel;

  // sel_i is one-hot or zero, so an OR-reduce forms the mux
  always_comb begin
    lo_sel = '0;
    snap_o = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (sel_i[k]) begin
        lo_sel = lo_sel | lo_b[k];
        snap_o = snap_o | hi_b[k];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) rdata_o = (half_i == HALF_HI) ? temp_i : lo_sel;
  end
endmodule

// File: rtl/wrb_bridge.sv
module wrb_bridge
  import wrb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [7:0]                 wdata_i,
  input  logic                       wr_i,
  input  logic                       rd_i,
  output logic [7:0]                 rdata_o,
  input  logic [NUM_REGS-1:0]        hw_we_i,
  input  logic [NUM_REGS*16-1:0]     hw_data_i,
  output logic [NUM_REGS*16-1:0]     reg_q_o,
  output logic [NUM_REGS-1:0]        commit_o
);
  bus_op_e             op;
  half_e               half;
  logic                hit;
  logic [NUM_REGS-1:0] sel;
  logic                wr_go, rd_go;
  logic [BYTE_W-1:0]   temp_q, snap;
  logic [WORD_W-1:0]   cpu_word;

  wrb_addr_dec #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .op_o   (op),
    .half_o (half),
    .hit_o  (hit),
    .sel_o  (sel)
  );

  assign wr_go    = (op == OP_WRITE) && hit;
  assign rd_go    = (op == OP_READ)  && hit;
  assign cpu_word = {temp_q, wdata_i};

  wrb_temp_byte u_temp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_wr_i (wr_go && (half == HALF_HI)),
    .wdata_i   (wdata_i),
    .load_rd_i (rd_go && (half == HALF_LO)),
    .snap_i    (snap),
    .temp_o    (temp_q)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
    assign commit_o[k] = wr_go && (half == HALF_LO) && sel[k];

    wrb_reg_slot u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cpu_commit_i (commit_o[k]),
      .cpu_word_i   (cpu_word),
      .hw_we_i      (hw_we_i[k]),
      .hw_word_i    (hw_data_i[k*WORD_W +: WORD_W]),
      .q_o          (reg_q_o[k*WORD_W +: WORD_W])
    );
  end

  wrb_rd_mux #(.NUM_REGS(NUM_REGS)) u_mux (
    .rd_en_i (rd_go),
    .half_i  (half),
    .sel_i   (sel),
    .words_i (reg_q_o),
    .temp_i  (temp_q),
    .rdata_o (rdata_o),
    .snap_o  (snap)
  );

  // R3
  commit_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(commit_o));

  // R4
  lo_read_snap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && hit && !addr_i[0]) |=> (temp_q == $past(snap)));

  // R9
  unmapped_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (rdata_o == '0 && commit_o == '0));

  // R10
  no_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i || wr_i) |-> (rdata_o == '0));
endmodule

// File: tb/wrb_bridge_tb.sv
`timescale 1ns/1ps
module wrb_bridge_tb_top;
  localparam int NR = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    addr = '0, wdata = '0, rdata;
  logic          wr = 1'b0, rd = 1'b0;
  logic [NR-1:0] hw_we = '0, commit;
  logic [NR*16-1:0] hw_data = '0, reg_q;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_reg [NR];
  logic [7:0]  m_temp;

  always #5 clk = ~clk;

  wrb_bridge #(.NUM_REGS(NR), .ADDR_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .hw_we_i(hw_we),
    .hw_data_i(hw_data), .reg_q_o(reg_q), .commit_o(commit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    for (int k = 0; k < NR; k++) chk(req, 32'(reg_q[k*16 +: 16]), 32'(m_reg[k]));
  endtask

  task automatic cyc(input logic w, input logic r, input logic [7:0] a,
                     input logic [7:0] d, input logic [NR-1:0] hwe,
                     input logic [NR*16-1:0] hwd, input string req);
    logic hit, lo;
    int idx;
    logic [7:0] exp_rd;
    logic [NR-1:0] exp_cm;
    logic [15:0] old [NR];
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d; hw_we = hwe; hw_data = hwd;
    #1;
    hit = (a >> 1) < NR;
    idx = int'(a[7:1]);
    lo  = !a[0];
    exp_rd = '0;
    if (r && !w && hit) exp_rd = lo ? m_reg[idx][7:0] : m_temp;
    exp_cm = '0;
    if (w && hit && lo) exp_cm[idx] = 1'b1;
    chk(req, 32'(rdata), 32'(exp_rd));
    chk(req, 32'(commit), 32'(exp_cm));
    for (int k = 0; k < NR; k++) old[k] = m_reg[k];
    for (int k = 0; k < NR; k++) begin
      if (exp_cm[k])   m_reg[k] = {m_temp, d};
      else if (hwe[k]) m_reg[k] = hwd[k*16 +: 16];
    end
    if (w && hit && !lo)             m_temp = d;
    else if (r && !w && hit && lo)   m_temp = old[idx][15:8];
    @(posedge clk);
    #1;
    wr = 1'b0; rd = 1'b0; hw_we = '0;
    chk_regs(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NR; k++) m_reg[k] = '0;
    m_temp = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", 32'(reg_q), 32'(0));
    chk("R1", 32'(commit), 32'(0));
    chk("R1", 32'(rdata), 32'(0));
    rst_n = 1'b1;
    cyc(0, 1, 8'd1, 8'h00, '0, '0, "R1");

    // R7 commit with reset temp
    cyc(1, 0, 8'd0, 8'h5A, '0, '0, "R7");

    // R2 R3 R6 R4 R5 sweep over every ordered pair
    for (int a = 0; a < NR; a++) begin
      for (int b = 0; b < NR; b++) begin
        logic [7:0] hv;
        hv = 8'(16 * a + 3 * b + 8'h31);
        cyc(1, 0, 8'(2*a+1), hv, '0, '0, "R2");
        cyc(1, 0, 8'(2*b), ~hv, '0, '0, "R6");
        cyc(0, 1, 8'(2*b), 8'h00, '0, '0, "R4");
        cyc(0, 1, 8'(2*b+1), 8'h00, '0, '0, "R5");
      end
    end

    // R5 stale high byte after peripheral update
    cyc(0, 1, 8'd4, 8'h00, '0, '0, "R4");
    cyc(0, 0, 8'd0, 8'h00, 4'b0100, 64'hABCD << 32, "R8");
    cyc(0, 1, 8'd5, 8'h00, '0, '0, "R5");
    cyc(0, 1, 8'd4, 8'h00, '0, '0, "R4");
    cyc(0, 1, 8'd5, 8'h00, '0, '0, "R5");

    // R8 peripheral load and collision
    cyc(0, 0, 8'd0, 8'h00, 4'b0010, 64'h1357 << 16, "R8");
    cyc(1, 0, 8'd7, 8'h11, '0, '0, "R3");
    cyc(1, 0, 8'd6, 8'h22, 4'b1000, 64'hFFFF << 48, "R8");
    cyc(0, 0, 8'd0, 8'h00, 4'b1111, 64'h0123_4567_89AB_CDEF, "R8");

    // R9 unmapped addresses
    cyc(1, 0, 8'd1, 8'h77, '0, '0, "R9");
    for (int a = 2 * NR; a < 256; a += 7) begin
      cyc(1, 0, 8'(a), 8'hC3, '0, '0, "R9");
      cyc(0, 1, 8'(a), 8'h00, '0, '0, "R9");
    end
    cyc(0, 1, 8'd3, 8'h00, '0, '0, "R9");

    // R10 simultaneous strobes and idle read data
    cyc(1, 1, 8'd2, 8'h9E, '0, '0, "R10");
    cyc(0, 0, 8'd1, 8'h00, '0, '0, "R10");
    cyc(1, 1, 8'd3, 8'h4B, '0, '0, "R10");
    cyc(0, 1, 8'd1, 8'h00, '0, '0, "R10");

    // R7 commit reusing a snapshot taken by a low-byte read
    cyc(0, 1, 8'd0, 8'h00, '0, '0, "R4");
    cyc(1, 0, 8'd2, 8'hE1, '0, '0, "R7");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule